// File: doc/BRIEF.md
# Serial Bus Target with Sticky Register Pointer

This block is the two-wire serial (I2C) target front end for a small bank of four byte-wide registers. It runs on a system clock that is much faster than the bus clock. It passes the raw SCL and SDA lines through two-flop synchronizers and finds start, repeated start and stop conditions, along with the rising and falling edges of SCL, from the synchronized samples. It drives the shared data line only through a pull-low enable. The surrounding logic joins that enable with the line to form the open-drain output.

The target answers one 7-bit address. Its upper four bits come from a parameter, binary 0011 by default, and its lower three bits come from strap pins. In a write transfer the byte after the address is a command byte. Its two low bits set a register pointer, and every later byte of that transfer is written to the register the pointer names. The pointer never advances, and it is kept across stops and repeated starts. A read transfer returns the selected register on every byte until the controller stops acknowledging. The register bank itself sits outside the block and connects through a select, a write strobe, write data and read data.

The system clock must run at least eight times faster than SCL.

Top module: `i2c_cmd_target`

## Requirements
- R1: While reset is held, and right after it is released, `sda_pull` is 0, `reg_wr` is 0 and `reg_sel` is 0.
- R2: The target matches an address byte whose upper seven bits, received MSB first, equal {ADDR_HI, strap[2:0]}. After a match it pulls SDA low for the ninth clock. The eighth bit selects the direction: 1 for read, 0 for write.
- R3: The target does not acknowledge an address byte that does not match. It then ignores all traffic, giving no acknowledge and no write strobe, until the next start condition.
- R4: The first byte after a write address sets the pointer to the byte's bits [1:0]. The upper six bits are ignored. The pointer appears on `reg_sel`, and the command byte produces no write strobe.
- R5: Each further byte of a write transfer gives exactly one single-cycle `reg_wr` pulse. `reg_wdata` carries the byte, received MSB first, and `reg_sel` stays unchanged between bytes.
- R6: The pointer keeps its value across stop conditions and repeated starts. A read that follows without a new command byte returns the register that was last selected.
- R7: In a read transfer every byte is the value of `reg_rdata` for the current `reg_sel`, sent MSB first. When the controller acknowledges, the target sends the same register again. When the controller gives a NACK, the target releases SDA and sends nothing more until the next start.
- R8: A start or stop condition in the middle of a byte abandons that byte. No write strobe is issued and the pointer is not changed.
- R9: The target acknowledges every byte it receives in a matched write transfer, including the command byte. The data line is always released once a stop condition is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line, as seen on the wire |
| strap | input | 3 | Low three address bits, held constant during a transfer |
| sda_pull | output | 1 | 1 pulls the data line low |
| reg_sel | output | 2 | Register pointer: 0 input, 1 output, 2 polarity, 3 direction |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Data that goes with `reg_wr` |
| reg_rdata | input | 8 | Value of the register that `reg_sel` names |

## Verification
The embedded properties hold on every cycle. After a start, the target is always waiting for a fresh address. A mismatched address always returns the target to idle. The pointer changes only when a command byte completes. The write strobe is always a single cycle. The bit counter never passes eight. The data line is released after any stop.

Only the bench scenarios can show the following at the pins. Acknowledgement works as the bus sees it. Read bytes are serialized correctly, one burst after another. The pointer survives across separate transfers. Aborted bytes leave the registers untouched, which the bench confirms by reading them back. Random write and read bursts, with random command bytes and random input levels, are compared against a bench model of the pointer and the register bank.

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [3:0] ADDR_HI = 4'b0011,
  parameter int         BITS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       strap,
  output logic             sda_pull,
  output logic [1:0]       reg_sel,
  output logic             reg_wr,
  output logic [BITS-1:0]  reg_wdata,
  input  logic [BITS-1:0]  reg_rdata
);

  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_WRITE, S_READ, S_RACK} state_t;

  state_t          state;
  logic [1:0]      scl_sync, sda_sync;
  logic            scl_q, sda_q;
  logic [BITS-1:0] shift;
  logic [CW-1:0]   cnt;
  logic            rw, cmd_phase, mack;
  logic [1:0]      ptr;

  wire scl_s = scl_sync[1];
  wire sda_s = sda_sync[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire addr_hit  = (shift[BITS-1:1] == {ADDR_HI, strap});

  assign sda_pull = (state == S_ACK) | ((state == S_READ) & ~shift[BITS-1]);
  assign reg_sel  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      shift     <= '0;
      cnt       <= '0;
      rw        <= 1'b0;
      cmd_phase <= 1'b0;
      mack      <= 1'b0;
      ptr       <= 2'd0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (start_det) begin
        state <= S_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              shift <= {shift[BITS-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              if (addr_hit) begin
                state     <= S_ACK;
                rw        <= shift[0];
                cmd_phase <= ~shift[0];
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                state <= S_READ;
                shift <= reg_rdata;
              end else begin
                state <= S_WRITE;
              end
            end
          end
          S_WRITE: begin
            if (scl_rise) begin
              shift <= {shift[BITS-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              state <= S_ACK;
              if (cmd_phase) begin
                ptr       <= shift[1:0];
                cmd_phase <= 1'b0;
              end else begin
                reg_wr    <= 1'b1;
                reg_wdata <= shift;
              end
            end
          end
          S_READ: begin
            if (scl_fall) begin
              shift <= {shift[BITS-2:0], 1'b0};
              cnt   <= cnt + 1'b1;
              if (cnt == LAST - 1'b1) state <= S_RACK;
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state <= S_READ;
                shift <= reg_rdata;
                cnt   <= '0;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_start_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_ADDR) && (cnt == '0));

  p_miss_to_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && !start_det && !stop_det && scl_fall && cnt == LAST && !addr_hit)
      |=> (state == S_IDLE));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_WRITE && cmd_phase && scl_fall && cnt == LAST) |=> $stable(reg_sel));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

endmodule

// File: tb/i2c_cmd_target_bench.sv
module i2c_cmd_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_pull, reg_wr;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata, reg_rdata, inp;
  logic [7:0] sink [4];
  int wr_cnt;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [1:0] exp_ptr;
  logic [7:0] exp_regs [4];

  wire sda_line = m_sda & ~sda_pull;

  always #4 clk = ~clk;

  i2c_cmd_target u_i2c_cmd_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap(strap),
    .sda_pull(sda_pull), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  assign reg_rdata = (reg_sel == 2'd0) ? inp : sink[reg_sel];

  always @(posedge clk) begin
    if (!rst_n) begin
      sink[0] <= 8'h00; sink[1] <= 8'h00; sink[2] <= 8'hF0; sink[3] <= 8'hFF;
      wr_cnt <= 0;
    end else if (reg_wr) begin
      wr_cnt <= wr_cnt + 1;
      if (reg_sel != 2'd0) sink[reg_sel] <= reg_wdata;
    end
  end

  function automatic logic [7:0] exp_read();
    return (exp_ptr == 2'd0) ? inp : exp_regs[exp_ptr];
  endfunction

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
    return {4'b0011, s, rd};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(4); m_scl = 1'b1; tick(8); m_sda = 1'b0; tick(8); m_scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(4); m_scl = 1'b1; tick(8); m_sda = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(4); m_scl = 1'b1; tick(8); m_scl = 1'b0; tick(4);
    end
    m_sda = 1'b1; tick(4); m_scl = 1'b1; tick(4);
    ack = ~sda_line;
    tick(4); m_scl = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(4); m_scl = 1'b1; tick(4);
      b[i] = sda_line;
      tick(4); m_scl = 1'b0; tick(4);
    end
    m_sda = ~give_ack; tick(4); m_scl = 1'b1; tick(8); m_scl = 1'b0; tick(4);
    m_sda = 1'b1;
  endtask

  task automatic write_data(input logic [7:0] d);
    logic ack;
    send_byte(d, ack);
    check("R9 data ack", ack, 1'b1);
    if (exp_ptr != 2'd0) exp_regs[exp_ptr] = d;
  endtask

  task automatic read_burst(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(req, b, exp_read());
    end
    tick(4);
    check("R7 released after NACK", sda_pull, 1'b0);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    logic ack;
    int w0;
    inp = 8'h5A;
    exp_ptr = 2'd0;
    exp_regs[0] = 8'h00; exp_regs[1] = 8'h00; exp_regs[2] = 8'hF0; exp_regs[3] = 8'hFF;
    void'($urandom(32'd20250611));
    tick(5);
    check("R1 pull in reset", sda_pull, 1'b0);
    check("R1 wr in reset", reg_wr, 1'b0);
    rst_n = 1'b1;
    tick(3);
    check("R1 sel after reset", reg_sel, 2'd0);
    check("R1 pull after reset", sda_pull, 1'b0);

    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    check("R2 address ack", ack, 1'b1);
    w0 = wr_cnt;
    send_byte(8'hFD, ack);
    check("R9 command ack", ack, 1'b1);
    exp_ptr = 2'd1;
    tick(2);
    check("R4 pointer from low bits", reg_sel, 2'd1);
    check("R4 no strobe for command", wr_cnt - w0, 0);
    write_data(8'h11);
    write_data(8'hA7);
    write_data(8'h3C);
    tick(2);
    check("R5 one strobe per byte", wr_cnt - w0, 3);
    check("R5 pointer not advanced", reg_sel, 2'd1);
    m_sda = 1'b1; tick(4); m_scl = 1'b1; tick(8); m_sda = 1'b0; tick(8); m_scl = 1'b0; tick(4);
    send_byte(addr_byte(strap, 1'b1), ack);
    check("R2 read address ack", ack, 1'b1);
    read_burst(3, "R6 R7 read after repeated start");
    bus_stop();

    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    check("R2 read ack", ack, 1'b1);
    read_burst(2, "R6 pointer kept across stop");
    bus_stop();

    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h02, ack);
    exp_ptr = 2'd2;
    w0 = wr_cnt;
    for (int i = 0; i < 4; i++) begin
      m_sda = i[0]; tick(4); m_scl = 1'b1; tick(8); m_scl = 1'b0; tick(4);
    end
    bus_stop();
    tick(4);
    check("R8 stop mid-byte no strobe", wr_cnt - w0, 0);
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    for (int i = 0; i < 5; i++) begin
      m_sda = 1'b1; tick(4); m_scl = 1'b1; tick(8); m_scl = 1'b0; tick(4);
    end
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    check("R8 start mid-command ack", ack, 1'b1);
    check("R8 pointer unchanged", reg_sel, 2'd2);
    read_burst(1, "R8 register unchanged");
    bus_stop();
    check("R8 no strobe after aborts", wr_cnt - w0, 0);

    bus_start();
    send_byte(addr_byte(strap ^ 3'b010, 1'b0), ack);
    check("R3 no ack on mismatch", ack, 1'b0);
    send_byte(8'h03, ack);
    check("R3 ignored byte not acked", ack, 1'b0);
    send_byte(8'h77, ack);
    bus_stop();
    check("R3 pointer untouched", reg_sel, 2'd2);
    check("R3 no strobe", wr_cnt - w0, 0);

    for (int t = 0; t < 30; t++) begin
      int kind, n;
      logic [7:0] cmd;
      kind = $urandom_range(0, 3);
      n = $urandom_range(1, 3);
      inp = 8'($urandom);
      bus_start();
      if (kind == 0) begin
        send_byte(addr_byte(strap, 1'b0), ack);
        check("R2 random write ack", ack, 1'b1);
        cmd = 8'($urandom);
        send_byte(cmd, ack);
        check("R9 random command ack", ack, 1'b1);
        exp_ptr = cmd[1:0];
        w0 = wr_cnt;
        for (int i = 0; i < n; i++) write_data(8'($urandom));
        tick(2);
        check("R5 random strobe count", wr_cnt - w0, n);
        check("R4 random pointer", reg_sel, exp_ptr);
        bus_stop();
      end else if (kind == 1) begin
        send_byte(addr_byte(strap, 1'b0), ack);
        cmd = 8'($urandom);
        send_byte(cmd, ack);
        exp_ptr = cmd[1:0];
        m_sda = 1'b1; tick(4); m_scl = 1'b1; tick(8); m_sda = 1'b0; tick(8); m_scl = 1'b0; tick(4);
        send_byte(addr_byte(strap, 1'b1), ack);
        check("R2 random read ack", ack, 1'b1);
        read_burst(n, "R7 random read after command");
        bus_stop();
      end else if (kind == 2) begin
        send_byte(addr_byte(strap, 1'b1), ack);
        read_burst(n, "R6 random read with kept pointer");
        bus_stop();
      end else begin
        send_byte(addr_byte(strap + 3'd1, 1'($urandom)), ack);
        check("R3 random mismatch", ack, 1'b0);
        bus_stop();
      end
    end
    done = 1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end
endmodule